// File: doc/BRIEF.md
# SCSI Pseudo-DMA Byte Lane Sequencer

This block sits between a 32-bit processor bus and the 8-bit data and register port of a SCSI controller. An access to the pseudo-DMA window is split into a short run of byte transactions against the controller's data register. The number of transactions comes from the active byte lanes of the access, and they are issued most significant lane first. On reads, each returned byte goes into its own lane of the 32-bit result.

Ordinary register accesses also pass through the block. It takes the controller register number from the halfword offset and moves one byte on the upper half of a 16-bit lane. Two particular offsets are flagged to the controller as pseudo-DMA byte accesses. A single-cycle request starts a sequence, and a single-cycle done pulse reports that it has finished.

Top module: `scsi_lane_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `prt_stb`, `bus_done` and `bus_rdata` are all zero.
- R2: A window access (`bus_win`=1) with byte enables 4'b1000 performs exactly one port transaction. A write sends `bus_wdata[31:24]`, and a read places the byte in `bus_rdata[31:24]`.
- R3: A window access with byte enables 4'b1100 performs two transactions. The first uses bits 31:24 and the second uses bits 23:16, for both writes and reads.
- R4: A window access with byte enables 4'b1111 performs four transactions, in the lane order 31:24, 23:16, 15:8, 7:0.
- R5: Every window read addresses controller register 6, and every window write addresses register 0. `prt_dma` is 1 on all window transactions. Whenever `prt_dma` is 1, the register is 6 for a read and 0 for a write.
- R6: A window access with any other byte-enable pattern makes no port transaction. A read then returns `bus_rdata` = 0, and `bus_done` still pulses.
- R7: An ordinary access (`bus_win`=0) makes exactly one transaction, whatever its byte enables. Its register number is `bus_hofs[6:3]`. A write sends `bus_wdata[15:8]`, and a read returns the byte in `bus_rdata[15:8]`.
- R8: For an ordinary access, `prt_dma` is 1 only for a read at halfword offset 9'h130 or a write at halfword offset 9'h100. It is 0 for every other ordinary access.
- R9: A request is accepted at a rising edge. The N strobes then appear in the N consecutive cycles that follow. `bus_done` is high for one cycle, in the cycle after the last strobe. For N=0 that is the cycle after acceptance.
- R10: `bus_rdata` is cleared when a request is accepted. Lanes that no read transaction fills stay zero. The value is held from `bus_done` until the next accepted request.
- R11: A request raised while a sequence is still strobing is ignored. It adds no transaction and no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = pseudo-DMA window, 0 = ordinary register access |
| bus_be | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_hofs | input | 9 | Halfword offset for ordinary accesses |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read result, valid from bus_done |
| bus_done | output | 1 | One-cycle completion pulse |
| prt_stb | output | 1 | Port transaction strobe, one cycle per byte |
| prt_we | output | 1 | Port transaction direction |
| prt_reg | output | 4 | Controller register number |
| prt_dma | output | 1 | Transaction is a pseudo-DMA byte access |
| prt_wdata | output | 8 | Byte written to the port |
| prt_rdata | input | 8 | Byte returned by the port during the strobe |

## Verification
The bench targets the byte-lane decode. A design that confused the two-lane and four-lane patterns, or that accepted a partial mask such as 4'b0110, would show the wrong number of strobes or a nonzero read. Lane order is checked byte by byte against a port model whose data depends on strobe number and register, so swapped or reversed lanes show up at once. The alias offsets 9'h100 and 9'h130 are tried in both directions, which exposes a flag that ignores direction. A second request raised mid-sequence catches a design that restarts or queues when it should ignore it. The done timing is checked cycle by cycle for every beat count, including zero.

// File: rtl/scsi_lane_pkg.sv
package scsi_lane_pkg;
  localparam int PORT_W = 8;
  localparam int REG_W  = 4;
  localparam int CNT_W  = 4;

  typedef logic [PORT_W-1:0] pbyte_t;
  typedef logic [REG_W-1:0]  regno_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Decoded description of one bus access
  typedef struct packed {
    cnt_t   beats;      // number of port transactions
    cnt_t   first_lane; // lane index of first byte, lane 0 = most significant
    regno_t regno;      // controller register
    logic   wr;         // direction
    logic   dma;        // pseudo-DMA flag toward the controller
  } xfer_plan_t;
endpackage

// File: rtl/lane_plan.sv
module lane_plan
  import scsi_lane_pkg::*;
#(
  parameter int   LANES       = 4,
  parameter int   HOFS_W      = 9,
  parameter int   REG_LSB     = 3,
  parameter int   RD_REG      = 6,
  parameter int   WR_REG      = 0,
  parameter logic [HOFS_W-1:0] RD_ALIAS = 9'h130,
  parameter logic [HOFS_W-1:0] WR_ALIAS = 9'h100
) (
  input  logic              we,
  input  logic              win,
  input  logic [LANES-1:0]  be,
  input  logic [HOFS_W-1:0] hofs,
  output xfer_plan_t        plan
);
  localparam logic [LANES-1:0] BE_TOP1 = LANES'(1) << (LANES-1);
  localparam logic [LANES-1:0] BE_TOP2 = LANES'(3) << (LANES-2);
  localparam logic [LANES-1:0] BE_ALL  = '1;
  localparam cnt_t             ORD_LANE = cnt_t'(LANES-2);

  cnt_t   win_beats;
  regno_t ord_reg;

  always_comb begin
    if (be == BE_ALL)       win_beats = cnt_t'(LANES);
    else if (be == BE_TOP2) win_beats = cnt_t'(2);
    else if (be == BE_TOP1) win_beats = cnt_t'(1);
    else                    win_beats = '0;
  end

  assign ord_reg = hofs[REG_LSB +: REG_W];

  always_comb begin
    plan.wr = we;
    if (win) begin
      plan.beats      = win_beats;
      plan.first_lane = '0;
      plan.regno      = we ? regno_t'(WR_REG) : regno_t'(RD_REG);
      plan.dma        = 1'b1;
    end else begin
      plan.beats      = cnt_t'(1);
      plan.first_lane = ORD_LANE;
      plan.regno      = ord_reg;
      plan.dma        = we ? ((hofs == WR_ALIAS) && (ord_reg == regno_t'(WR_REG)))
                           : ((hofs == RD_ALIAS) && (ord_reg == regno_t'(RD_REG)));
    end
  end
endmodule

// File: rtl/beat_seq.sv
module beat_seq
  import scsi_lane_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  xfer_plan_t       plan,
  input  logic [BUS_W-1:0] wdata_al,
  output logic             busy,
  output logic             done,
  output logic             stb,
  output logic             we_o,
  output regno_t           reg_o,
  output logic             dma_o,
  output pbyte_t           wbyte_o,
  output cnt_t             lane_o
);
  logic [BUS_W-1:0] shift_q;
  cnt_t             remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      stb      <= 1'b0;
      we_o     <= 1'b0;
      reg_o    <= '0;
      dma_o    <= 1'b0;
      wbyte_o  <= '0;
      lane_o   <= '0;
      shift_q  <= '0;
      remain_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        we_o   <= plan.wr;
        reg_o  <= plan.regno;
        dma_o  <= plan.dma;
        lane_o <= plan.first_lane;
        if (plan.beats == '0) begin
          done <= 1'b1;
        end else begin
          busy     <= 1'b1;
          stb      <= 1'b1;
          remain_q <= plan.beats - cnt_t'(1);
          wbyte_o  <= wdata_al[BUS_W-1 -: PORT_W];
          shift_q  <= wdata_al << PORT_W;
        end
      end else if (busy) begin
        if (remain_q == '0) begin
          busy <= 1'b0;
          stb  <= 1'b0;
          done <= 1'b1;
        end else begin
          remain_q <= remain_q - cnt_t'(1);
          lane_o   <= lane_o + cnt_t'(1);
          wbyte_o  <= shift_q[BUS_W-1 -: PORT_W];
          shift_q  <= shift_q << PORT_W;
        end
      end
    end
  end
endmodule

// File: rtl/read_pack.sv
module read_pack
  import scsi_lane_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             cap,
  input  cnt_t             lane,
  input  pbyte_t           byte_in,
  output logic [BUS_W-1:0] rdata
);
  localparam int LANES = BUS_W / PORT_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear)
        rdata[BUS_W-1-PORT_W*j -: PORT_W] <= '0;
      else if (cap && (lane == cnt_t'(j)))
        rdata[BUS_W-1-PORT_W*j -: PORT_W] <= byte_in;
    end
  end
endmodule

// File: rtl/scsi_lane_seq.sv
module scsi_lane_seq
  import scsi_lane_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int HOFS_W  = 9,
  parameter int REG_LSB = 3,
  parameter int RD_REG  = 6,
  parameter int WR_REG  = 0,
  parameter logic [HOFS_W-1:0] RD_ALIAS = 9'h130,
  parameter logic [HOFS_W-1:0] WR_ALIAS = 9'h100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic                    bus_win,
  input  logic [BUS_W/PORT_W-1:0] bus_be,
  input  logic [HOFS_W-1:0]       bus_hofs,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic                    bus_done,
  output logic                    prt_stb,
  output logic                    prt_we,
  output logic [REG_W-1:0]        prt_reg,
  output logic                    prt_dma,
  output logic [PORT_W-1:0]       prt_wdata,
  input  logic [PORT_W-1:0]       prt_rdata
);
  localparam int LANES     = BUS_W / PORT_W;
  localparam int ORD_SHIFT = PORT_W * (LANES - 2);

  xfer_plan_t       plan;
  logic             seq_busy;
  logic             accept;
  logic [BUS_W-1:0] wdata_al;
  cnt_t             cur_lane;

  assign accept   = bus_req & ~seq_busy;
  assign wdata_al = bus_win ? bus_wdata : (bus_wdata << ORD_SHIFT);

  lane_plan #(
    .LANES(LANES), .HOFS_W(HOFS_W), .REG_LSB(REG_LSB),
    .RD_REG(RD_REG), .WR_REG(WR_REG), .RD_ALIAS(RD_ALIAS), .WR_ALIAS(WR_ALIAS)
  ) plan_i (
    .we(bus_we), .win(bus_win), .be(bus_be), .hofs(bus_hofs), .plan(plan)
  );

  beat_seq #(.BUS_W(BUS_W)) seq_i (
    .clk(clk), .rst(rst), .start(accept), .plan(plan), .wdata_al(wdata_al),
    .busy(seq_busy), .done(bus_done), .stb(prt_stb), .we_o(prt_we),
    .reg_o(prt_reg), .dma_o(prt_dma), .wbyte_o(prt_wdata), .lane_o(cur_lane)
  );

  read_pack #(.BUS_W(BUS_W)) pack_i (
    .clk(clk), .rst(rst), .clear(accept), .cap(prt_stb & ~prt_we),
    .lane(cur_lane), .byte_in(prt_rdata), .rdata(bus_rdata)
  );
endmodule

// File: rtl/scsi_lane_seq_chk.sv
module scsi_lane_seq_chk
  import scsi_lane_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int RD_REG = 6,
  parameter int WR_REG = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             accept,
  input logic             bus_done,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             prt_stb,
  input logic             prt_we,
  input logic [REG_W-1:0] prt_reg,
  input logic             prt_dma
);
  localparam int LANES = BUS_W / PORT_W;

  cnt_t beat_cnt;
  always_ff @(posedge clk) begin
    if (rst || accept) beat_cnt <= '0;
    else if (prt_stb)  beat_cnt <= beat_cnt + cnt_t'(1);
  end

  // R9: done is a single pulse unless a new zero-beat access follows
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_done && !accept) |=> !bus_done);
  // R9: strobing ends exactly when done rises
  p_stb_fall_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(prt_stb) |-> bus_done);
  // R9: no strobe while done
  p_done_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
    bus_done |-> !prt_stb);
  // R5: pseudo-DMA transactions target the data register for their direction
  p_dma_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (prt_stb && prt_dma) |-> (prt_reg == (prt_we ? REG_W'(WR_REG) : REG_W'(RD_REG))));
  // R10: result held when no capture and no new access
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!prt_stb && !accept) |=> $stable(bus_rdata));
  // R4: never more transactions than lanes per access
  p_beats_max_r4: assert property (@(posedge clk) disable iff (rst)
    beat_cnt <= cnt_t'(LANES));
endmodule

bind scsi_lane_seq scsi_lane_seq_chk #(
  .BUS_W(BUS_W), .RD_REG(RD_REG), .WR_REG(WR_REG)
) chk_i (
  .clk(clk), .rst(rst), .accept(accept), .bus_done(bus_done),
  .bus_rdata(bus_rdata), .prt_stb(prt_stb), .prt_we(prt_we),
  .prt_reg(prt_reg), .prt_dma(prt_dma)
);

// File: tb/scsi_lane_seq_tb_top.sv
module scsi_lane_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [8:0]  bus_hofs = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_done, prt_stb, prt_we, prt_dma;
  logic [3:0]  prt_reg;
  logic [7:0]  prt_wdata, prt_rdata;

  int checks = 0;
  int fails  = 0;
  int stb_total = 0;
  int done_total = 0;
  logic [7:0] log_wb  [64];
  logic [3:0] log_reg [64];
  logic       log_dma [64];
  logic       log_we  [64];

  always #5 clk = ~clk;

  scsi_lane_seq dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_be(bus_be), .bus_hofs(bus_hofs), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .prt_stb(prt_stb),
    .prt_we(prt_we), .prt_reg(prt_reg), .prt_dma(prt_dma),
    .prt_wdata(prt_wdata), .prt_rdata(prt_rdata)
  );

  function automatic logic [7:0] port_byte(int n, logic [3:0] r);
    return 8'((n * 7) + (int'(r) * 16) + 3);
  endfunction

  assign prt_rdata = port_byte(stb_total, prt_reg);

  always @(posedge clk) begin
    if (prt_stb) begin
      log_wb[stb_total % 64]  <= prt_wdata;
      log_reg[stb_total % 64] <= prt_reg;
      log_dma[stb_total % 64] <= prt_dma;
      log_we[stb_total % 64]  <= prt_we;
      stb_total <= stb_total + 1;
    end
    if (bus_done) done_total <= done_total + 1;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_beats(logic win, logic [3:0] be);
    if (!win) return 1;
    case (be)
      4'b1000: return 1;
      4'b1100: return 2;
      4'b1111: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic run(logic we, logic win, logic [3:0] be, logic [8:0] hofs, logic [31:0] wd);
    int n, base, d0;
    logic [3:0] er;
    logic edma;
    logic [31:0] erd;
    logic [7:0] eb;
    bit early, gap;
    string tag;
    n    = exp_beats(win, be);
    er   = win ? (we ? 4'd0 : 4'd6) : hofs[6:3];
    edma = win ? 1'b1 : (we ? (hofs == 9'h100) : (hofs == 9'h130));
    if (!win) tag = "R7";
    else if (n == 1) tag = "R2";
    else if (n == 2) tag = "R3";
    else if (n == 4) tag = "R4";
    else tag = "R6";
    @(negedge clk);
    base = stb_total; d0 = done_total;
    bus_we = we; bus_win = win; bus_be = be; bus_hofs = hofs; bus_wdata = wd;
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    early = 0; gap = 0;
    for (int i = 0; i < n; i++) begin
      if (bus_done) early = 1;
      if (!prt_stb) gap = 1;
      @(negedge clk);
    end
    // R9: done exactly one cycle after the last strobe
    chk(!early && !gap && bus_done && !prt_stb, "R9 timing",
        {early, gap, bus_done, prt_stb}, 32'h2);
    chk(stb_total - base == n, tag, stb_total - base, n);
    erd = '0;
    for (int k = 0; k < n; k++) begin
      int ix = (base + k) % 64;
      chk(log_reg[ix] == er && log_we[ix] == we, win ? "R5 reg" : "R7 reg",
          {log_we[ix], log_reg[ix]}, {we, er});
      chk(log_dma[ix] == edma, win ? "R5 dma" : "R8 dma", log_dma[ix], edma);
      if (we) begin
        eb = win ? wd[31-8*k -: 8] : wd[15:8];
        chk(log_wb[ix] == eb, tag, log_wb[ix], eb);
      end else if (win) erd[31-8*k -: 8] = port_byte(base + k, er);
      else erd[15:8] = port_byte(base, er);
    end
    // R10: unfilled lanes zero, write leaves cleared result
    chk(bus_rdata == erd, we ? "R10" : tag, bus_rdata, erd);
    @(negedge clk);
    chk(!bus_done && bus_rdata == erd && done_total - d0 == 1, "R10 hold",
        {bus_done, bus_rdata[30:0]}, {1'b0, erd[30:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base, d0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(!prt_stb && !bus_done && bus_rdata == 0, "R1 in reset",
        {prt_stb, bus_done, bus_rdata[29:0]}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!prt_stb && !bus_done && bus_rdata == 0, "R1 after reset",
        {prt_stb, bus_done, bus_rdata[29:0]}, 0);

    // directed window cases
    run(1, 1, 4'b1000, 9'h0, 32'hA1B2C3D4);  // R2
    run(0, 1, 4'b1000, 9'h0, 32'h0);         // R2
    run(1, 1, 4'b1100, 9'h0, 32'h11223344);  // R3
    run(0, 1, 4'b1100, 9'h0, 32'h0);         // R3
    run(1, 1, 4'b1111, 9'h0, 32'hDEADBEEF);  // R4
    run(0, 1, 4'b1111, 9'h0, 32'h0);         // R4
    run(0, 1, 4'b0110, 9'h0, 32'h0);         // R6
    run(0, 1, 4'b0000, 9'h0, 32'h0);         // R6
    run(1, 1, 4'b0011, 9'h0, 32'h55555555);  // R6
    run(0, 1, 4'b1110, 9'h0, 32'h0);         // R6
    // ordinary accesses and alias offsets
    run(0, 0, 4'b1111, 9'h130, 32'h0);       // R8 read alias
    run(1, 0, 4'b0011, 9'h100, 32'h0000AB00); // R8 write alias
    run(0, 0, 4'b1100, 9'h100, 32'h0);       // R8 read at write alias, no flag
    run(1, 0, 4'b1100, 9'h130, 32'h00007700); // R8 write at read alias, no flag
    run(1, 0, 4'b0001, 9'h038, 32'hFFFF12FF); // R7 reg 7

    // R11: second request during a sequence is ignored
    @(negedge clk);
    base = stb_total; d0 = done_total;
    bus_we = 1; bus_win = 1; bus_be = 4'b1111; bus_wdata = 32'h01020304;
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
    bus_be = 4'b1000; bus_wdata = 32'hFF000000; bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(stb_total - base == 4 && done_total - d0 == 1, "R11",
        {stb_total - base, done_total - d0}, {32'd4, 32'd1});

    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [3:0] be;
      logic [8:0] hofs;
      case ($urandom_range(0, 4))
        0: be = 4'b1000;
        1: be = 4'b1100;
        2: be = 4'b1111;
        default: be = 4'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: hofs = 9'h130;
        1: hofs = 9'h100;
        default: hofs = 9'($urandom);
      endcase
      run(1'($urandom), 1'($urandom), be, hofs, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule